// File: doc/BRIEF.md
# Transmit Word FIFO with Status Flags

This block buffers outgoing data words between a register bus and a serial data-path shifter. Software, or a DMA engine, writes 32-bit words into a window of consecutive word addresses. Every address in that window pushes into the same 16-entry queue, so a burst of incrementing addresses fills the buffer in order. A registered output port always presents the oldest stored word. When the shifter takes that word, it pulses a load strobe. The strobe retires the word and exposes the next one on the following cycle.

The block keeps five registered status flags: full, empty, half-empty, data-available and a sticky underrun. The half-empty flag is meant to drive a DMA request. The underrun flag records a load request made while the queue was empty during an active transmission, and it stays set until a dedicated clear strobe. A transmit-enable input gates the whole block. While the enable is low, bus writes are ignored, both pointers return to zero and every flag reads low.

Top module: `tx_word_fifo`

## Requirements
- R1: While reset is held, and on the first cycle after reset with the enable low, all five flags read 0.
- R2: With the enable high, a bus write whose word address lies in the window (addresses 0x20 to 0x2F by default, upper address bits equal to the base) pushes one word. Which address in the window is used makes no difference. A write outside the window has no effect.
- R3: The full flag is 1 exactly when 16 words are stored. A bus write while the queue is full is discarded, and the stored contents stay unchanged.
- R4: The empty flag is 1 exactly when no word is stored. While the enable is high, the data-available flag is always the inverse of empty.
- R5: The half-empty flag is 1 exactly when at least 8 entries are free, that is, when 8 or fewer words are stored.
- R6: While at least one word is stored, the data output equals the oldest stored word. Words leave in the order they were written, and each load strobe retires exactly one word.
- R7: A load strobe while the queue is empty leaves the queue unchanged. A word pushed afterwards appears on the data output as the oldest word.
- R8: A load strobe with the queue empty and the transmit-active input high sets the underrun flag. The flag stays set until a clear strobe. If set and clear occur in the same cycle, set wins. A load on an empty queue with transmit-active low does not set the flag.
- R9: While the enable is low, every flag reads 0, bus writes are ignored and the queue is emptied. After the enable is raised again, the block reports empty.
- R10: A push and a load in the same cycle on a queue that is neither empty nor full leave the stored count unchanged. The queue drops the oldest word and appends the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Transmit enable; low empties the queue and forces the flags low |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 6 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| urun_clr | input | 1 | Clear strobe for the underrun flag |
| shift_load | input | 1 | Shifter load strobe; retires the oldest word |
| tx_active | input | 1 | Data path is transmitting |
| tx_data | output | 32 | Oldest stored word (registered) |
| flag_full | output | 1 | Queue holds 16 words |
| flag_empty | output | 1 | Queue holds no word |
| flag_half_empty | output | 1 | 8 or more entries free (DMA request) |
| flag_data_avail | output | 1 | Inverse of empty while enabled |
| flag_underrun | output | 1 | Sticky underrun indication |

## Verification
A bus push and a shifter load can land on the same clock edge. So can an underrun set and an underrun clear. The bench provokes both pairs directly: a run of combined push and load cycles at a mid-level fill, a combined push and load on a full queue and on an empty queue, and a load on an empty queue issued together with the clear strobe. A long random phase then overlaps all strobes freely. A behavioural queue model decides the outcome every cycle. The flags, the stored count implied by them and the oldest word are compared against it after each edge.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic half_empty;
    logic avail;
    logic underrun;
  } txf_flags_t;

endpackage

// File: rtl/txf_ptr_ctrl.sv
module txf_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             is_empty,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr_nxt,
  output logic [CNT_W-1:0] count_nxt
);

  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             is_full;

  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_W'(DEPTH));
  assign push_ok  = push_req & ~is_full;
  assign pop_ok   = pop_req & ~is_empty;

  always_comb begin
    if (!en) begin
      rd_ptr_nxt = '0;
      count_nxt  = '0;
    end else begin
      rd_ptr_nxt = rd_ptr + PTR_W'(pop_ok);
      case ({push_ok, pop_ok})
        2'b10:   count_nxt = count + CNT_W'(1);
        2'b01:   count_nxt = count - CNT_W'(1);
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_ok);
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register follows the next read pointer; a word written to that
  // same slot in this cycle is forwarded so the output never goes stale.
  always_ff @(posedge clk) begin
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end

endmodule

// File: rtl/txf_flags.sv
module txf_flags
  import txf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             urun_set,
  input  logic             urun_clr,
  output txf_flags_t       flags
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      flags <= '0;
    end else begin
      flags.full       <= (count_nxt == FULL_LVL);
      flags.empty      <= (count_nxt == '0);
      flags.half_empty <= (count_nxt <= HALF_LVL);
      flags.avail      <= (count_nxt != '0);
      if (urun_set)      flags.underrun <= 1'b1;
      else if (urun_clr) flags.underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 6,
  parameter int WIN_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              urun_clr,
  input  logic              shift_load,
  input  logic              tx_active,
  output logic [DATA_W-1:0] tx_data,
  output logic              flag_full,
  output logic              flag_empty,
  output logic              flag_half_empty,
  output logic              flag_data_avail,
  output logic              flag_underrun
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

  logic             in_win, push_req, pop_req, push_ok, pop_ok, is_empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] count_nxt;
  txf_flags_t       flags;

  assign in_win   = (bus_addr[ADDR_W-1:PTR_W] == BASE_V[ADDR_W-1:PTR_W]);
  assign push_req = fifo_en & bus_wr & in_win;
  assign pop_req  = fifo_en & shift_load;

  txf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .en        (fifo_en),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .is_empty  (is_empty),
    .wr_ptr    (wr_ptr),
    .rd_ptr_nxt(rd_ptr_nxt),
    .count_nxt (count_nxt)
  );

  txf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wr_ptr),
    .wdata(bus_wdata),
    .raddr(rd_ptr_nxt),
    .rdata(tx_data)
  );

  txf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .en       (fifo_en),
    .count_nxt(count_nxt),
    .urun_set (pop_req & is_empty & tx_active),
    .urun_clr (urun_clr),
    .flags    (flags)
  );

  assign flag_full       = flags.full;
  assign flag_empty      = flags.empty;
  assign flag_half_empty = flags.half_empty;
  assign flag_data_avail = flags.avail;
  assign flag_underrun   = flags.underrun;

  logic unused_pop;
  assign unused_pop = pop_ok;

endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_en,
  input logic              bus_wr,
  input logic              urun_clr,
  input logic              shift_load,
  input logic [DATA_W-1:0] tx_data,
  input logic              flag_full,
  input logic              flag_empty,
  input logic              flag_half_empty,
  input logic              flag_data_avail,
  input logic              flag_underrun
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) && !$past(fifo_en) |->
      !(flag_full | flag_empty | flag_half_empty | flag_data_avail | flag_underrun));

  p_full_not_empty_r3: assert property (@(posedge clk) disable iff (rst)
    !(flag_full && flag_empty));

  p_avail_inverse_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fifo_en) |-> (flag_data_avail != flag_empty));

  p_full_not_half_r5: assert property (@(posedge clk) disable iff (rst)
    flag_full |-> !flag_half_empty);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fifo_en) && !$past(bus_wr) && !$past(shift_load)
      |-> $stable(tx_data));

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(flag_underrun) && $past(fifo_en) && !$past(urun_clr) |-> flag_underrun);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_en) |->
      !(flag_full | flag_empty | flag_half_empty | flag_data_avail | flag_underrun));

endmodule

bind tx_word_fifo txf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fifo_en        (fifo_en),
  .bus_wr         (bus_wr),
  .urun_clr       (urun_clr),
  .shift_load     (shift_load),
  .tx_data        (tx_data),
  .flag_full      (flag_full),
  .flag_empty     (flag_empty),
  .flag_half_empty(flag_half_empty),
  .flag_data_avail(flag_data_avail),
  .flag_underrun  (flag_underrun)
);

// File: tb/tb_tx_word_fifo.sv
module tb_tx_word_fifo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b0, bus_wr = 1'b0, urun_clr = 1'b0;
  logic        shift_load = 1'b0, tx_active = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] tx_data;
  logic        flag_full, flag_empty, flag_half_empty, flag_data_avail, flag_underrun;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] q[$];
  logic        m_en = 1'b0, m_und = 1'b0, m_rst = 1'b1;

  always #2.5 clk = ~clk;

  tx_word_fifo dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .urun_clr(urun_clr), .shift_load(shift_load),
    .tx_active(tx_active), .tx_data(tx_data), .flag_full(flag_full),
    .flag_empty(flag_empty), .flag_half_empty(flag_half_empty),
    .flag_data_avail(flag_data_avail), .flag_underrun(flag_underrun)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference model, evaluated on each rising edge.
  always @(posedge clk) begin
    cyc++;
    m_rst = rst;
    m_en  = fifo_en;
    if (rst || !fifo_en) begin
      q.delete();
      m_und = 1'b0;
    end else begin
      automatic bit was_empty = (q.size() == 0);
      automatic bit was_full  = (q.size() == 16);
      if (shift_load && was_empty && tx_active) m_und = 1'b1;
      else if (urun_clr) m_und = 1'b0;
      if (shift_load && !was_empty) void'(q.pop_front());
      if (bus_wr && bus_addr[5:4] == 2'b10 && !was_full) q.push_back(bus_wdata);
    end
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!m_rst && cyc > 0) begin
      automatic int n = q.size();
      automatic bit on = m_en;
      check(flag_full == (on && n == 16), "R3 full", 32'(flag_full), 32'(on && n == 16));
      check(flag_empty == (on && n == 0), "R4 empty", 32'(flag_empty), 32'(on && n == 0));
      check(flag_data_avail == (on && n != 0), "R4 avail", 32'(flag_data_avail), 32'(on && n != 0));
      check(flag_half_empty == (on && n <= 8), "R5 half", 32'(flag_half_empty), 32'(on && n <= 8));
      check(flag_underrun == m_und, "R8 underrun", 32'(flag_underrun), 32'(m_und));
      if (on && n > 0) check(tx_data == q[0], "R6 data", tx_data, q[0]);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; shift_load = 0; urun_clr = 0;
  endtask

  task automatic push(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step(); idle();
  endtask

  task automatic load(input logic act);
    shift_load = 1; tx_active = act; step(); idle();
  endtask

  initial begin
    @(negedge clk);
    repeat (3) step();
    check(!(flag_full | flag_empty | flag_half_empty | flag_data_avail | flag_underrun),
          "R1 reset flags", {27'd0, flag_full, flag_empty, flag_half_empty, flag_data_avail,
          flag_underrun}, 32'd0);
    rst = 0;
    step();
    check(flag_empty == 0, "R1 enable low after reset", 32'(flag_empty), 0);
    fifo_en = 1;
    step();
    check(flag_empty && flag_half_empty, "R4 empty after enable", 32'(flag_empty), 1);

    // R2: out-of-window writes ignored, every alias pushes
    push(6'h10, 32'hDEAD0001);
    push(6'h30, 32'hDEAD0002);
    check(flag_empty == 1, "R2 out-of-window write ignored", 32'(flag_empty), 1);
    for (int i = 0; i < 16; i++) push(6'h20 + 6'(i), 32'hA000_0000 + 32'(i));
    check(flag_full == 1, "R2 sixteen aliased addresses fill", 32'(flag_full), 1);
    push(6'h25, 32'hBAD0_BAD0);
    check(tx_data == 32'hA000_0000, "R3 write when full discarded", tx_data, 32'hA000_0000);

    // R10 style: push and load on full queue (push refused)
    bus_wr = 1; bus_addr = 6'h2F; bus_wdata = 32'hCCCC_0000; shift_load = 1; tx_active = 1;
    step(); idle();
    check(tx_data == 32'hA000_0001, "R6 advance on load", tx_data, 32'hA000_0001);

    // drain to empty
    for (int i = 0; i < 15; i++) load(1'b1);
    check(flag_empty && !flag_underrun, "R6 drained without underrun", 32'(flag_underrun), 0);

    // R7/R8: load on empty, without and with transmit-active
    load(1'b0);
    check(flag_underrun == 0, "R8 no underrun when idle", 32'(flag_underrun), 0);
    load(1'b1);
    check(flag_underrun == 1, "R8 underrun set", 32'(flag_underrun), 1);
    step();
    check(flag_underrun == 1, "R8 underrun sticky", 32'(flag_underrun), 1);
    shift_load = 1; tx_active = 1; urun_clr = 1; step(); idle();
    check(flag_underrun == 1, "R8 set beats clear", 32'(flag_underrun), 1);
    urun_clr = 1; step(); idle();
    check(flag_underrun == 0, "R8 clear strobe", 32'(flag_underrun), 0);
    // push and load together on empty: push lands
    bus_wr = 1; bus_addr = 6'h21; bus_wdata = 32'h7777_0007; shift_load = 1; tx_active = 0;
    step(); idle();
    check(tx_data == 32'h7777_0007 && !flag_empty, "R7 empty load leaves queue intact",
          tx_data, 32'h7777_0007);

    // R10: simultaneous push/load at mid level
    for (int i = 0; i < 4; i++) push(6'h22, 32'hB000_0000 + 32'(i));
    for (int i = 0; i < 10; i++) begin
      bus_wr = 1; bus_addr = 6'h2A; bus_wdata = 32'hC000_0000 + 32'(i);
      shift_load = 1; tx_active = 1; step(); idle();
    end
    check(q.size() == 5 && !flag_empty && flag_half_empty, "R10 count unchanged",
          32'(q.size()), 32'd5);

    // R5: boundary at 8 and 9 stored words
    push(6'h20, 32'h1); push(6'h20, 32'h2); push(6'h20, 32'h3);
    check(flag_half_empty == 1, "R5 eight stored", 32'(flag_half_empty), 1);
    push(6'h20, 32'h4);
    check(flag_half_empty == 0, "R5 nine stored", 32'(flag_half_empty), 0);

    // R9: disable with data, writes ignored
    fifo_en = 0;
    push(6'h20, 32'hEEEE_EEEE);
    check(!(flag_full | flag_empty | flag_half_empty | flag_data_avail), "R9 flags low",
          32'(flag_data_avail), 0);
    fifo_en = 1; step();
    check(flag_empty == 1, "R9 emptied on disable", 32'(flag_empty), 1);

    // random overlap phase
    for (int i = 0; i < 600; i++) begin
      bus_wr     = ($urandom % 3) != 0;
      bus_addr   = ($urandom % 5 == 0) ? 6'(($urandom % 64)) : 6'h20 + 6'($urandom % 16);
      bus_wdata  = $urandom;
      shift_load = ($urandom % 2) == 1;
      tx_active  = ($urandom % 4) != 0;
      urun_clr   = ($urandom % 8) == 0;
      fifo_en    = ($urandom % 40) != 0;
      step();
    end
    idle();
    fifo_en = 1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule